// File: doc/BRIEF.md
# NAND Page Program and Erase Engine

This block is the storage back end of a small NAND flash model. It keeps a few erase blocks of pages in a register array. Every page has a data area and a spare area, and a spare area is one thirty-second of the data size. A command front end uses the block in three steps. It fills a program buffer one byte at a time. It then issues one request: program, erase or load. While the engine runs it reports busy, and it raises a one-cycle done pulse with a success flag when the request ends.

The engine follows NAND cell rules. A program never sets a bit. Each buffered byte is ANDed into the byte already stored, so a bit can only go from 1 to 0. The only way back to all ones is a block erase, which writes 0xFF to every data and spare byte of the block that holds the addressed page. A protect input, sampled when a request is accepted, blocks program and erase. Requests that name a page past the end of the array are dropped. A load streams the page from a chosen column to the end of the spare area, one byte per cycle.

Top module: `nand_pe_engine`

## Requirements
- R1: After reset every stored byte reads 0xFF, `busy` is 0 and `done` is 0.
- R2: A program request (`req_op`=0) ANDs buffered byte i into the stored byte at column `req_col`+i of page `req_row`. Programming the same bytes twice leaves the AND of both patterns.
- R3: Each page holds PAGE_BYTES data bytes plus PAGE_BYTES/32 spare bytes (66 bytes by default). A load (`req_op`=2) from column c returns 66−c bytes on `rd_byte`, each marked by `rd_valid`, in ascending column order.
- R4: `buf_clear` empties the program buffer. The buffer keeps at most one full page plus spare of pushed bytes and drops every byte after that. A program from an empty buffer changes nothing and reports success.
- R5: While `wp_allow` is 0 at acceptance, a program or an erase changes no byte and completes with `done_ok`=0.
- R6: An erase (`req_op`=1) first keeps only the low `req_row_bytes` bytes of `req_row`. It aligns the resulting page down to its block of 2^BLOCK_SHIFT pages and writes 0xFF to every data and spare byte of that block only.
- R7: A program, erase or load whose page number is NUM_PAGES or more changes nothing, streams nothing and completes with `done_ok`=0.
- R8: A load whose column is greater than the page-plus-spare size fails with `done_ok`=0 and no bytes. A column equal to that size succeeds with no bytes.
- R9: `busy` is high from the cycle after acceptance through the `done` cycle. `done` lasts one cycle. Requests and buffer writes made while `busy` is high are ignored.
- R10: Program bytes that would land past the end of the spare area are discarded, so a program started near the end of a page touches only that page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_allow | input | 1 | 1 lets program and erase proceed; sampled at acceptance |
| buf_clear | input | 1 | Empty the program buffer |
| buf_push | input | 1 | Append `buf_byte` to the program buffer |
| buf_byte | input | 8 | Byte to append |
| req_valid | input | 1 | Request strobe; taken when not busy |
| req_op | input | 2 | 0 program, 1 erase, 2 load |
| req_row | input | ROW_BYTES*8 | Page number (raw row for erase) |
| req_row_bytes | input | $clog2(ROW_BYTES+1) | Number of valid row bytes for an erase |
| req_col | input | COL_W | Starting column for program and load |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Operation took effect; valid with `done` |
| rd_valid | output | 1 | `rd_byte` carries a loaded byte |
| rd_byte | output | 8 | Loaded byte |

## Verification
The hardest case to reach from the ports is a request that arrives while an erase is still filling its block. The stimulus loads a zero pattern into the buffer and starts an erase. Two cycles later it pulses a program request for a page inside that block. The bench then checks that exactly one done pulse appears and that the block reads back all 0xFF. The row masking before an erase is also easy to miss. A row with stray high bytes, given together with a short byte count, must erase the block picked by the low bytes alone.

// File: rtl/nand_eng_pkg.sv
package nand_eng_pkg;

    typedef enum logic [1:0] {
        OP_PROGRAM = 2'd0,
        OP_ERASE   = 2'd1,
        OP_LOAD    = 2'd2
    } nand_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } seq_state_e;

    // Decoded plan for one accepted request.
    typedef struct packed {
        logic        go;    // walk bytes
        logic        ok;    // result when no walk is needed
        logic [31:0] base;  // first cell index
        logic [31:0] len;   // bytes to walk
    } op_plan_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    function automatic int unsigned spare_of(input int unsigned page_bytes);
        return page_bytes / 32;
    endfunction

    function automatic logic [63:0] low_byte_mask(input int unsigned nbytes);
        if (nbytes >= 8) return '1;
        return (64'd1 << (nbytes * 8)) - 64'd1;
    endfunction

    function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/nand_prog_buffer.sv
module nand_prog_buffer #(
    parameter int DEPTH = 66,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             clear,
    input  logic             push,
    input  logic [7:0]       din,
    input  logic [CNT_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic [CNT_W-1:0] count
);
    logic [7:0] slots [DEPTH];
    logic       has_room;

    assign has_room = (32'(count) < DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (enable) begin
            if (clear) begin
                count <= '0;
            end else if (push && has_room) begin
                slots[count] <= din;
                count        <= count + 1'b1;
            end
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (32'(rd_idx) < DEPTH) rd_data = slots[rd_idx];
    end
endmodule

// File: rtl/nand_cell_array.sv
module nand_cell_array #(
    parameter int CELLS  = 528,
    parameter int CELL_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CELL_W-1:0] addr,
    input  logic              we,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    import nand_eng_pkg::*;

    logic [7:0] cells [CELLS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CELLS; i++) cells[i] <= ERASED_BYTE;
        end else if (we && (32'(addr) < CELLS)) begin
            cells[addr] <= wdata;
        end
    end

    always_comb begin
        rdata = ERASED_BYTE;
        if (32'(addr) < CELLS) rdata = cells[addr];
    end
endmodule

// File: rtl/nand_op_sequencer.sv
module nand_op_sequencer
    import nand_eng_pkg::*;
#(
    parameter int PAGE_TOTAL  = 66,
    parameter int NUM_PAGES   = 8,
    parameter int BLOCK_SHIFT = 2,
    parameter int ROW_W       = 16,
    parameter int NB_W        = 2,
    parameter int COL_W       = 8,
    parameter int CELL_W      = 10,
    parameter int CNT_W       = 7,
    parameter int IDX_W       = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_allow,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [NB_W-1:0]   req_row_bytes,
    input  logic [COL_W-1:0]  req_col,
    input  logic [CNT_W-1:0]  buf_count,
    input  logic [7:0]        buf_rdata,
    input  logic [7:0]        cell_rdata,
    output logic [CNT_W-1:0]  buf_idx,
    output logic [CELL_W-1:0] cell_addr,
    output logic              cell_we,
    output logic [7:0]        cell_wdata,
    output logic              busy,
    output logic              done,
    output logic              done_ok,
    output logic              rd_valid,
    output logic [7:0]        rd_byte
);
    localparam int BLOCK_PAGES = 1 << BLOCK_SHIFT;
    localparam int ERASE_SPAN  = BLOCK_PAGES * PAGE_TOTAL;

    seq_state_e        state;
    nand_op_e          op_q;
    logic [CELL_W-1:0] base_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  len_q;
    logic              ok_q;
    op_plan_t          plan;
    logic [ROW_W-1:0]  row_kept;
    logic              accept;

    assign accept = req_valid && (state == ST_IDLE);

    // Request decode: range checks, masking and span computation.
    always_comb begin
        int unsigned page_u;
        int unsigned col_u;
        int unsigned room;
        int unsigned first_page;
        plan     = '0;
        row_kept = req_row & ROW_W'(low_byte_mask(32'(req_row_bytes)));
        page_u   = 32'(req_row);
        col_u    = 32'(req_col);
        room     = (col_u < PAGE_TOTAL) ? (PAGE_TOTAL - col_u) : 0;
        first_page = 0;
        case (nand_op_e'(req_op))
            OP_PROGRAM: begin
                if (wp_allow && page_u < NUM_PAGES) begin
                    plan.len  = min_u(32'(buf_count), room);
                    plan.base = page_u * PAGE_TOTAL + col_u;
                    plan.go   = (plan.len != 0);
                    plan.ok   = 1'b1;
                end
            end
            OP_ERASE: begin
                first_page = (32'(row_kept) >> BLOCK_SHIFT) << BLOCK_SHIFT;
                if (wp_allow && 32'(row_kept) < NUM_PAGES) begin
                    plan.len  = ERASE_SPAN;
                    plan.base = first_page * PAGE_TOTAL;
                    plan.go   = 1'b1;
                    plan.ok   = 1'b1;
                end
            end
            OP_LOAD: begin
                if (page_u < NUM_PAGES && col_u <= PAGE_TOTAL) begin
                    plan.len  = room;
                    plan.base = page_u * PAGE_TOTAL + col_u;
                    plan.go   = (room != 0);
                    plan.ok   = 1'b1;
                end
            end
            default: plan = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            op_q     <= OP_PROGRAM;
            base_q   <= '0;
            idx_q    <= '0;
            len_q    <= '0;
            ok_q     <= 1'b0;
            rd_valid <= 1'b0;
            rd_byte  <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        op_q   <= nand_op_e'(req_op);
                        idx_q  <= '0;
                        base_q <= CELL_W'(plan.base);
                        len_q  <= IDX_W'(plan.len);
                        ok_q   <= plan.ok;
                        state  <= plan.go ? ST_RUN : ST_FIN;
                    end
                end
                ST_RUN: begin
                    if (op_q == OP_LOAD) begin
                        rd_valid <= 1'b1;
                        rd_byte  <= cell_rdata;
                    end
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == len_q - 1'b1) state <= ST_FIN;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cell_addr  = base_q + CELL_W'(idx_q);
    assign buf_idx    = CNT_W'(idx_q);
    assign cell_we    = (state == ST_RUN) && (op_q != OP_LOAD);
    assign cell_wdata = (op_q == OP_ERASE) ? ERASED_BYTE : (cell_rdata & buf_rdata);
    assign busy       = (state != ST_IDLE);
    assign done       = (state == ST_FIN);
    assign done_ok    = ok_q;
endmodule

// File: rtl/nand_pe_engine.sv
module nand_pe_engine
    import nand_eng_pkg::*;
#(
    parameter int PAGE_BYTES  = 64,
    parameter int BLOCK_SHIFT = 2,
    parameter int NUM_BLOCKS  = 2,
    parameter int ROW_BYTES   = 2,
    parameter int PAGE_TOTAL  = PAGE_BYTES + PAGE_BYTES / 32,
    parameter int COL_W       = $clog2(PAGE_TOTAL) + 1,
    parameter int ROW_W       = ROW_BYTES * 8,
    parameter int NB_W        = $clog2(ROW_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wp_allow,
    input  logic             buf_clear,
    input  logic             buf_push,
    input  logic [7:0]       buf_byte,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [ROW_W-1:0] req_row,
    input  logic [NB_W-1:0]  req_row_bytes,
    input  logic [COL_W-1:0] req_col,
    output logic             busy,
    output logic             done,
    output logic             done_ok,
    output logic             rd_valid,
    output logic [7:0]       rd_byte
);
    localparam int SPARE_BYTES = spare_of(PAGE_BYTES);
    localparam int NUM_PAGES   = NUM_BLOCKS << BLOCK_SHIFT;
    localparam int CELLS       = NUM_PAGES * (PAGE_BYTES + SPARE_BYTES);
    localparam int CELL_W      = $clog2(CELLS);
    localparam int CNT_W       = $clog2(PAGE_TOTAL + 1);
    localparam int IDX_W       = $clog2((PAGE_TOTAL << BLOCK_SHIFT) + 1);

    logic [CNT_W-1:0]  buf_count;
    logic [CNT_W-1:0]  buf_idx;
    logic [7:0]        buf_rdata;
    logic [CELL_W-1:0] cell_addr;
    logic              cell_we;
    logic [7:0]        cell_wdata;
    logic [7:0]        cell_rdata;

    nand_prog_buffer #(
        .DEPTH (PAGE_TOTAL),
        .CNT_W (CNT_W)
    ) buf_i (
        .clk     (clk),
        .rst     (rst),
        .enable  (~busy),
        .clear   (buf_clear),
        .push    (buf_push),
        .din     (buf_byte),
        .rd_idx  (buf_idx),
        .rd_data (buf_rdata),
        .count   (buf_count)
    );

    nand_cell_array #(
        .CELLS  (CELLS),
        .CELL_W (CELL_W)
    ) array_i (
        .clk   (clk),
        .rst   (rst),
        .addr  (cell_addr),
        .we    (cell_we),
        .wdata (cell_wdata),
        .rdata (cell_rdata)
    );

    nand_op_sequencer #(
        .PAGE_TOTAL  (PAGE_TOTAL),
        .NUM_PAGES   (NUM_PAGES),
        .BLOCK_SHIFT (BLOCK_SHIFT),
        .ROW_W       (ROW_W),
        .NB_W        (NB_W),
        .COL_W       (COL_W),
        .CELL_W      (CELL_W),
        .CNT_W       (CNT_W),
        .IDX_W       (IDX_W)
    ) seq_i (
        .clk           (clk),
        .rst           (rst),
        .wp_allow      (wp_allow),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .req_row       (req_row),
        .req_row_bytes (req_row_bytes),
        .req_col       (req_col),
        .buf_count     (buf_count),
        .buf_rdata     (buf_rdata),
        .cell_rdata    (cell_rdata),
        .buf_idx       (buf_idx),
        .cell_addr     (cell_addr),
        .cell_we       (cell_we),
        .cell_wdata    (cell_wdata),
        .busy          (busy),
        .done          (done),
        .done_ok       (done_ok),
        .rd_valid      (rd_valid),
        .rd_byte       (rd_byte)
    );
endmodule

// File: rtl/nand_pe_engine_chk.sv
module nand_pe_engine_chk #(
    parameter int PAGE_BYTES  = 64,
    parameter int BLOCK_SHIFT = 2,
    parameter int NUM_BLOCKS  = 2,
    parameter int ROW_W       = 16,
    parameter int COL_W       = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wp_allow,
    input logic             req_valid,
    input logic [1:0]       req_op,
    input logic [ROW_W-1:0] req_row,
    input logic [COL_W-1:0] req_col,
    input logic             busy,
    input logic             done,
    input logic             done_ok,
    input logic             rd_valid
);
    localparam int TOTAL     = PAGE_BYTES + PAGE_BYTES / 32;
    localparam int NUM_PAGES = NUM_BLOCKS << BLOCK_SHIFT;

    logic             accept;
    logic [1:0]       lat_op;
    logic             lat_wp;
    logic [ROW_W-1:0] lat_row;
    logic [COL_W-1:0] lat_col;
    int unsigned      streamed;

    assign accept = req_valid && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_op   <= '0;
            lat_wp   <= 1'b0;
            lat_row  <= '0;
            lat_col  <= '0;
            streamed <= 0;
        end else if (accept) begin
            lat_op   <= req_op;
            lat_wp   <= wp_allow;
            lat_row  <= req_row;
            lat_col  <= req_col;
            streamed <= 0;
        end else if (rd_valid) begin
            streamed <= streamed + 1;
        end
    end

    // R9: acceptance starts busy
    a_r9_accept_busy: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);
    // R9: done is inside busy, single cycle, then idle
    a_r9_done_in_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
    a_r9_stream_in_busy: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> busy);
    // R5: protect blocks program and erase
    a_r5_protect_fails: assert property (@(posedge clk) disable iff (rst)
        (done && lat_op != 2'd2 && !lat_wp) |-> !done_ok);
    // R7: out-of-range program and load are dropped
    a_r7_range_fails: assert property (@(posedge clk) disable iff (rst)
        (done && lat_op != 2'd1 && 32'(lat_row) >= NUM_PAGES) |-> !done_ok);
    // R8: column past page plus spare fails the load
    a_r8_col_fails: assert property (@(posedge clk) disable iff (rst)
        (done && lat_op == 2'd2 && 32'(lat_col) > TOTAL) |-> !done_ok);
    // R3: successful load streams exactly TOTAL minus column bytes
    a_r3_load_count: assert property (@(posedge clk) disable iff (rst)
        (done && lat_op == 2'd2 && done_ok) |->
            (streamed + 32'(rd_valid) == TOTAL - 32'(lat_col)));
endmodule

bind nand_pe_engine nand_pe_engine_chk #(
    .PAGE_BYTES  (PAGE_BYTES),
    .BLOCK_SHIFT (BLOCK_SHIFT),
    .NUM_BLOCKS  (NUM_BLOCKS),
    .ROW_W       (ROW_W),
    .COL_W       (COL_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wp_allow  (wp_allow),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_row   (req_row),
    .req_col   (req_col),
    .busy      (busy),
    .done      (done),
    .done_ok   (done_ok),
    .rd_valid  (rd_valid)
);

// File: tb/nand_pe_engine_tb_top.sv
`timescale 1ns/1ps
module nand_pe_engine_tb_top;
    localparam int T  = 66;   // page plus spare
    localparam int BP = 4;    // pages per block
    localparam int NP = 8;    // pages in array

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wp_allow = 1'b1;
    logic        buf_clear = 1'b0;
    logic        buf_push = 1'b0;
    logic [7:0]  buf_byte = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [15:0] req_row = '0;
    logic [1:0]  req_row_bytes = 2'd2;
    logic [7:0]  req_col = '0;
    logic        busy, done, done_ok, rd_valid;
    logic [7:0]  rd_byte;

    nand_pe_engine dut_i (
        .clk(clk), .rst(rst), .wp_allow(wp_allow), .buf_clear(buf_clear),
        .buf_push(buf_push), .buf_byte(buf_byte), .req_valid(req_valid),
        .req_op(req_op), .req_row(req_row), .req_row_bytes(req_row_bytes),
        .req_col(req_col), .busy(busy), .done(done), .done_ok(done_ok),
        .rd_valid(rd_valid), .rd_byte(rd_byte)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [7:0] ref_mem [NP*T];
    logic [7:0] got [128];
    int   got_n;
    logic got_ok;

    // Vector fields: op, row, row_bytes, col, seed, len, wp, expected ok
    localparam logic [45:0] VEC [10] = '{
        {2'd0, 16'h0001, 2'd2, 8'd0,  8'hA5, 8'd66, 1'b1, 1'b1},  // R2
        {2'd0, 16'h0001, 2'd2, 8'd0,  8'h3C, 8'd66, 1'b1, 1'b1},  // R2 twice
        {2'd0, 16'h0002, 2'd2, 8'd60, 8'h0F, 8'd10, 1'b1, 1'b1},  // R10
        {2'd0, 16'h0003, 2'd2, 8'd0,  8'h00, 8'd20, 1'b0, 1'b0},  // R5
        {2'd0, 16'h0006, 2'd2, 8'd0,  8'h5A, 8'd66, 1'b1, 1'b1},  // R2
        {2'd1, 16'h0001, 2'd2, 8'd0,  8'h00, 8'd0,  1'b0, 1'b0},  // R5
        {2'd1, 16'h0105, 2'd1, 8'd0,  8'h00, 8'd0,  1'b1, 1'b1},  // R6
        {2'd0, 16'h0009, 2'd2, 8'd0,  8'hC3, 8'd8,  1'b1, 1'b0},  // R7
        {2'd1, 16'h0009, 2'd2, 8'd0,  8'h00, 8'd0,  1'b1, 1'b0},  // R7
        {2'd1, 16'h0802, 2'd0, 8'd0,  8'h00, 8'd0,  1'b1, 1'b1}   // R6
    };

    function automatic string vec_tag(input int k);
        case (k)
            0, 1, 4: return "R2";
            2:       return "R10";
            3, 5:    return "R5";
            6, 9:    return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return seed ^ 8'(i * 7);
    endfunction

    task automatic check(input logic cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic fill_buf(input logic [7:0] seed, input int len);
        buf_clear = 1'b1;
        @(negedge clk);
        buf_clear = 1'b0;
        for (int i = 0; i < len; i++) begin
            buf_push = 1'b1;
            buf_byte = pat(seed, i);
            @(negedge clk);
        end
        buf_push = 1'b0;
    endtask

    task automatic issue(input logic [1:0] op, input logic [15:0] row,
                         input logic [1:0] nb, input logic [7:0] col, input logic wp);
        got_n = 0;
        got_ok = 1'b0;
        wp_allow = wp; req_op = op; req_row = row; req_row_bytes = nb; req_col = col;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t < 2000; t++) begin
            if (rd_valid && got_n < 128) begin got[got_n] = rd_byte; got_n++; end
            if (done) begin got_ok = done_ok; break; end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic ref_program(input int page, input int col, input logic [7:0] seed, input int len);
        int n;
        n = (len < T) ? len : T;
        for (int i = 0; i < n; i++)
            if (col + i < T) ref_mem[page*T + col + i] &= pat(seed, i);
    endtask

    task automatic ref_erase(input int page);
        int first;
        first = (page / BP) * BP;
        for (int i = 0; i < BP*T; i++) ref_mem[first*T + i] = 8'hFF;
    endtask

    task automatic verify_page(input int p, input string tag);
        int mism;
        mism = 0;
        issue(2'd2, 16'(p), 2'd2, 8'd0, 1'b1);
        for (int i = 0; i < T; i++)
            if (i >= got_n || got[i] !== ref_mem[p*T + i]) mism++;
        check(got_ok && got_n == T && mism == 0, tag, mism, 0);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NP*T; i++) ref_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle outputs and erased array
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        for (int p = 0; p < NP; p++) verify_page(p, "R1");

        // Table walk
        for (int k = 0; k < 10; k++) begin
            logic [1:0]  op;  logic [15:0] row; logic [1:0] nb; logic [7:0] col;
            logic [7:0]  sd;  logic [7:0]  ln;  logic wp; logic ex;
            int          kept;
            {op, row, nb, col, sd, ln, wp, ex} = VEC[k];
            if (op == 2'd0) fill_buf(sd, int'(ln));
            issue(op, row, nb, col, wp);
            check(got_ok == ex, vec_tag(k), got_ok, ex);
            if (op == 2'd0 && wp && row < NP) ref_program(int'(row), int'(col), sd, int'(ln));
            kept = (nb == 2'd0) ? 0 : (nb == 2'd1) ? int'(row[7:0]) : int'(row);
            if (op == 2'd1 && wp && kept < NP) ref_erase(kept);
            for (int p = 0; p < NP; p++) verify_page(p, vec_tag(k));
        end

        // R8: column at and past the end
        issue(2'd2, 16'd1, 2'd2, 8'd66, 1'b1);
        check(got_ok == 1'b1 && got_n == 0, "R8 col end", got_n, 0);
        issue(2'd2, 16'd1, 2'd2, 8'd67, 1'b1);
        check(got_ok == 1'b0 && got_n == 0, "R8 col past", got_ok, 0);
        // R7: load out of range
        issue(2'd2, 16'd8, 2'd2, 8'd0, 1'b1);
        check(got_ok == 1'b0 && got_n == 0, "R7 load range", got_ok, 0);

        // R3: load from a middle column
        fill_buf(8'h77, T);
        issue(2'd0, 16'd1, 2'd2, 8'd0, 1'b1);
        ref_program(1, 0, 8'h77, T);
        issue(2'd2, 16'd1, 2'd2, 8'd10, 1'b1);
        begin
            int mism;
            mism = 0;
            for (int i = 0; i < got_n; i++) if (got[i] !== ref_mem[T + 10 + i]) mism++;
            check(got_ok && got_n == T - 10 && mism == 0, "R3 partial load", got_n, T - 10);
        end

        // R4: cleared buffer programs nothing
        fill_buf(8'h00, 5);
        buf_clear = 1'b1; @(negedge clk); buf_clear = 1'b0;
        issue(2'd0, 16'd4, 2'd2, 8'd0, 1'b1);
        check(got_ok == 1'b1, "R4 empty program", got_ok, 1);
        verify_page(4, "R4 clear");
        // R4: overflow bytes dropped
        buf_clear = 1'b1; @(negedge clk); buf_clear = 1'b0;
        for (int i = 0; i < T + 4; i++) begin
            buf_push = 1'b1; buf_byte = (i < T) ? 8'hFF : 8'h00; @(negedge clk);
        end
        buf_push = 1'b0;
        issue(2'd0, 16'd2, 2'd2, 8'd0, 1'b1);
        verify_page(2, "R4 overflow");
        verify_page(3, "R4 overflow next");

        // R9: request during an erase is ignored
        fill_buf(8'h00, 4);
        wp_allow = 1'b1; req_op = 2'd1; req_row = 16'd5; req_row_bytes = 2'd2;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R9 busy after accept", busy, 1);
        @(negedge clk);
        req_op = 2'd0; req_row = 16'd5; req_col = 8'd0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        begin
            int dones;
            dones = 0;
            for (int t = 0; t < 400; t++) begin
                if (done) dones++;
                @(negedge clk);
            end
            check(dones == 1, "R9 single done", dones, 1);
            check(busy == 1'b0, "R9 idle", busy, 0);
        end
        ref_erase(5);
        verify_page(5, "R9 ignored program");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule